// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block runs one external bus transaction at a time for an 8-bit processor with a 16-bit address space. A request interface supplies a cycle kind, an address and write data. The block drives the upper address byte on dedicated pins. The lower address byte and the data share a single byte of pins: in the first clock of a transaction that byte carries the address while an address-latch strobe is high, and in the later clocks it carries data. Active-low read and write strobes, and three status lines that encode the cycle kind, tell the outside world what is happening.

Slow devices stretch a transaction by holding a ready input low, which adds wait clocks. An external master can take the bus by raising a hold request. The block finishes any transaction already under way, raises a hold acknowledge and floats every bus output. Each tri-state output is modelled as a value plus an output enable. Completion is reported by a one-clock done pulse, with the captured read byte alongside it.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: While reset is asserted, every output enable (addr_hi_oe_o, ad_oe_o, ctrl_oe_o) is low, hold_ack_o is low and both strobes are high.
- R2: In the first clock after a request is accepted, ale_o is high, ad_o carries address bits [7:0] with ad_oe_o high, addr_hi_o carries bits [15:8], and both strobes are high. ale_o is low in every other clock.
- R3: The read kinds 010, 110, 011 and 111 hold rd_n_o low, and the write kinds 001 and 101 hold wr_n_o low, from the second clock of the transaction to its last. Kind 000 (halt) drives neither strobe. The two strobes are never low together.
- R4: status_o = {io_m, s1, s0} equals the request kind for the whole transaction. Bit 2 is high for I/O kinds and low for memory kinds.
- R5: During the data clocks of a write, ad_oe_o is high and ad_o carries the write data. During the data clocks of any other kind, ad_oe_o is low.
- R6: When ready_i is sampled low in the second clock of a transaction, or in a wait clock, the next clock is a wait clock. A wait clock keeps the strobes, the status and the upper address unchanged. Each low sample adds exactly one clock.
- R7: For read kinds, ad_i is captured at the clock edge that ends the strobe. done_o pulses for one clock after every transaction, and rdata_o holds the captured byte.
- R8: A hold request is honoured only between transactions. A transaction in progress runs to completion first. At a boundary, a hold request takes priority over a pending request.
- R9: While hold_ack_o is high, all output enables and req_ready_o are low, and no request is accepted.
- R10: hold_ack_o falls at the first clock edge that samples hold_i low. A request that was pending then starts one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted at this edge when valid |
| req_kind_i | input | 3 | Cycle kind {io_m,s1,s0} |
| req_addr_i | input | 16 | Transaction address |
| req_wdata_i | input | 8 | Write data |
| done_o | output | 1 | One-clock pulse after a transaction ends |
| rdata_o | output | 8 | Captured read byte |
| ready_i | input | 1 | Device ready; low inserts wait clocks |
| hold_i | input | 1 | Bus hold request |
| hold_ack_o | output | 1 | Bus hold acknowledge |
| addr_hi_o | output | 8 | Upper address byte |
| addr_hi_oe_o | output | 1 | Output enable for addr_hi_o |
| ad_o | output | 8 | Shared address/data byte, outgoing value |
| ad_i | input | 8 | Shared address/data byte, incoming value |
| ad_oe_o | output | 1 | Output enable for ad_o |
| ale_o | output | 1 | Address latch strobe |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| status_o | output | 3 | Cycle status {io_m,s1,s0} |
| ctrl_oe_o | output | 1 | Output enable for ale, strobes and status |

## Verification
The hardest case to reach from the ports is a hold request that arrives in the middle of a stretched transaction. The bench raises hold_i during the second clock of a read while ready_i is held low. It then confirms that the strobe stays low through the wait clocks, that hold_ack_o stays low until done_o has pulsed, and that the acknowledge appears only on the following clock. A second hold scenario raises hold_i together with a pending request. It checks that the request is refused for the whole hold, and that the request starts one clock after hold_ack_o falls.

// File: rtl/bus_cycle_pkg.sv
package bus_cycle_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_T1, ST_T2, ST_TW, ST_T3, ST_HOLD
  } bus_state_e;

  localparam logic [2:0] KIND_HALT  = 3'b000;
  localparam logic [2:0] KIND_MWR   = 3'b001;
  localparam logic [2:0] KIND_MRD   = 3'b010;
  localparam logic [2:0] KIND_FETCH = 3'b011;
  localparam logic [2:0] KIND_IOWR  = 3'b101;
  localparam logic [2:0] KIND_IORD  = 3'b110;
  localparam logic [2:0] KIND_INTA  = 3'b111;

  function automatic logic kind_is_read(input logic [2:0] k);
    return k[1];
  endfunction

  function automatic logic kind_is_write(input logic [2:0] k);
    return k[1:0] == 2'b01;
  endfunction
endpackage

// File: rtl/bus_seq.sv
module bus_seq
  import bus_cycle_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic       ready_i,
  input  logic       hold_i,
  output bus_state_e state_o,
  output logic       accept_o,
  output logic       hold_ack_o
);
  bus_state_e state_q, state_d;

  // hold wins over a pending request at a boundary
  assign accept_o   = (state_q == ST_IDLE) && !hold_i && req_valid_i;
  assign hold_ack_o = (state_q == ST_HOLD);
  assign state_o    = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (hold_i)           state_d = ST_HOLD;
        else if (req_valid_i) state_d = ST_T1;
      end
      ST_T1:   state_d = ST_T2;
      ST_T2:   state_d = ready_i ? ST_T3 : ST_TW;
      ST_TW:   state_d = ready_i ? ST_T3 : ST_TW;
      ST_T3:   state_d = ST_IDLE;
      ST_HOLD: state_d = hold_i ? ST_HOLD : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/bus_req_reg.sv
module bus_req_reg #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [2:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [2:0]        kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_o  <= '0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (load_i) begin
      kind_o  <= kind_i;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end
endmodule

// File: rtl/bus_pin_drv.sv
module bus_pin_drv
  import bus_cycle_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
  input  bus_state_e        state_i,
  input  logic              bus_en_i,
  input  logic [2:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [HI_W-1:0]   addr_hi_o,
  output logic              addr_hi_oe_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic              ale_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic [2:0]        status_o,
  output logic              ctrl_oe_o
);
  logic data_phase;
  assign data_phase = (state_i == ST_T2) || (state_i == ST_TW) || (state_i == ST_T3);
  assign addr_hi_o  = addr_i[ADDR_W-1:DATA_W];
  assign status_o   = kind_i;

  always_comb begin
    ale_o        = 1'b0;
    rd_n_o       = 1'b1;
    wr_n_o       = 1'b1;
    ad_o         = addr_i[DATA_W-1:0];
    ad_oe_o      = 1'b0;
    addr_hi_oe_o = bus_en_i;
    ctrl_oe_o    = bus_en_i;
    if (state_i == ST_HOLD) begin
      addr_hi_oe_o = 1'b0;
      ctrl_oe_o    = 1'b0;
    end else if (state_i == ST_T1) begin
      ale_o   = 1'b1;
      ad_oe_o = bus_en_i;
    end else if (data_phase) begin
      rd_n_o = !kind_is_read(kind_i);
      wr_n_o = !kind_is_write(kind_i);
      if (kind_is_write(kind_i)) begin
        ad_o    = wdata_i;
        ad_oe_o = bus_en_i;
      end
    end
  end
endmodule

// File: rtl/bus_rd_cap.sv
module bus_rd_cap
  import bus_cycle_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_state_e        state_i,
  input  logic [2:0]        kind_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= (state_i == ST_T3);
      if (state_i == ST_T3 && kind_is_read(kind_i)) rdata_o <= ad_i;
    end
  end
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import bus_cycle_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [2:0]        req_kind_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ready_i,
  input  logic              hold_i,
  output logic              hold_ack_o,
  output logic [HI_W-1:0]   addr_hi_o,
  output logic              addr_hi_oe_o,
  output logic [DATA_W-1:0] ad_o,
  input  logic [DATA_W-1:0] ad_i,
  output logic              ad_oe_o,
  output logic              ale_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic [2:0]        status_o,
  output logic              ctrl_oe_o
);
  bus_state_e        state_w;
  logic              accept_w;
  logic              bus_en_q;
  logic [2:0]        kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  // pins stay floated until the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bus_en_q <= 1'b0;
    else         bus_en_q <= 1'b1;
  end

  assign req_ready_o = (state_w == ST_IDLE) && !hold_i;

  bus_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .ready_i     (ready_i),
    .hold_i      (hold_i),
    .state_o     (state_w),
    .accept_o    (accept_w),
    .hold_ack_o  (hold_ack_o)
  );

  bus_req_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept_w),
    .kind_i  (req_kind_i),
    .addr_i  (req_addr_i),
    .wdata_i (req_wdata_i),
    .kind_o  (kind_q),
    .addr_o  (addr_q),
    .wdata_o (wdata_q)
  );

  bus_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
    .state_i      (state_w),
    .bus_en_i     (bus_en_q),
    .kind_i       (kind_q),
    .addr_i       (addr_q),
    .wdata_i      (wdata_q),
    .addr_hi_o    (addr_hi_o),
    .addr_hi_oe_o (addr_hi_oe_o),
    .ad_o         (ad_o),
    .ad_oe_o      (ad_oe_o),
    .ale_o        (ale_o),
    .rd_n_o       (rd_n_o),
    .wr_n_o       (wr_n_o),
    .status_o     (status_o),
    .ctrl_oe_o    (ctrl_oe_o)
  );

  bus_rd_cap #(.DATA_W(DATA_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_i (state_w),
    .kind_i  (kind_q),
    .ad_i    (ad_i),
    .done_o  (done_o),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/bus_cycle_ctrl_chk.sv
module bus_cycle_ctrl_chk
  import bus_cycle_pkg::*;
#(
  parameter int unsigned HI_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input bus_state_e      state_w,
  input logic            ready_i,
  input logic            hold_i,
  input logic            hold_ack_o,
  input logic            req_ready_o,
  input logic            ale_o,
  input logic            rd_n_o,
  input logic            wr_n_o,
  input logic            ad_oe_o,
  input logic            addr_hi_oe_o,
  input logic            ctrl_oe_o,
  input logic [HI_W-1:0] addr_hi_o,
  input logic [2:0]      status_o
);
  always_comb begin
    if (!rst_ni) begin
      assert_reset_float_R1: assert (!ad_oe_o && !addr_hi_oe_o && !ctrl_oe_o && !hold_ack_o);
    end
  end

  assert_ale_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (rd_n_o && wr_n_o && ad_oe_o));

  assert_strobe_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && !wr_n_o));

  assert_wdata_phase_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ad_oe_o && !ale_o) |-> !wr_n_o);

  assert_wait_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_w == ST_T2 || state_w == ST_TW) && !ready_i) |=>
      (state_w == ST_TW && $stable(addr_hi_o) && $stable(rd_n_o)
       && $stable(wr_n_o) && $stable(status_o)));

  assert_hold_boundary_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_ack_o) |-> $past(state_w == ST_IDLE));

  assert_hold_float_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_ack_o |-> (!ad_oe_o && !addr_hi_oe_o && !ctrl_oe_o && !req_ready_o));

  assert_hold_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_ack_o && !hold_i) |=> !hold_ack_o);
endmodule

bind bus_cycle_ctrl bus_cycle_ctrl_chk #(.HI_W(HI_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .state_w      (state_w),
  .ready_i      (ready_i),
  .hold_i       (hold_i),
  .hold_ack_o   (hold_ack_o),
  .req_ready_o  (req_ready_o),
  .ale_o        (ale_o),
  .rd_n_o       (rd_n_o),
  .wr_n_o       (wr_n_o),
  .ad_oe_o      (ad_oe_o),
  .addr_hi_oe_o (addr_hi_oe_o),
  .ctrl_oe_o    (ctrl_oe_o),
  .addr_hi_o    (addr_hi_o),
  .status_o     (status_o)
);

// File: tb/bus_cycle_ctrl_tb_top.sv
module bus_cycle_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0;
  logic       req_ready_o;
  logic [2:0] req_kind_i = '0;
  logic [15:0] req_addr_i = '0;
  logic [7:0] req_wdata_i = '0;
  logic       done_o;
  logic [7:0] rdata_o;
  logic       ready_i = 1'b1;
  logic       hold_i = 1'b0;
  logic       hold_ack_o;
  logic [7:0] addr_hi_o;
  logic       addr_hi_oe_o;
  logic [7:0] ad_o;
  logic [7:0] ad_i = '0;
  logic       ad_oe_o;
  logic       ale_o;
  logic       rd_n_o;
  logic       wr_n_o;
  logic [2:0] status_o;
  logic       ctrl_oe_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bus_cycle_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_kind_i(req_kind_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .done_o(done_o), .rdata_o(rdata_o), .ready_i(ready_i), .hold_i(hold_i),
    .hold_ack_o(hold_ack_o), .addr_hi_o(addr_hi_o), .addr_hi_oe_o(addr_hi_oe_o),
    .ad_o(ad_o), .ad_i(ad_i), .ad_oe_o(ad_oe_o), .ale_o(ale_o), .rd_n_o(rd_n_o),
    .wr_n_o(wr_n_o), .status_o(status_o), .ctrl_oe_o(ctrl_oe_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, req, what, act, exp);
  endtask

  // one transaction; hold_mid raises hold_i during the second clock
  task automatic do_cycle(input logic [2:0] kind, input logic [15:0] addr,
                          input logic [7:0] wdata, input int waits,
                          input logic [7:0] rdval, input bit hold_mid);
    bit is_rd = kind[1];
    bit is_wr = (kind[1:0] == 2'b01);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_kind_i = kind; req_addr_i = addr; req_wdata_i = wdata;
    ready_i = (waits == 0);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk_eq("R2", "ale first clock", {31'd0, ale_o}, 1);
    chk_eq("R2", "low addr on ad", {23'd0, ad_oe_o, ad_o}, {23'd0, 1'b1, addr[7:0]});
    chk_eq("R2", "high addr", {24'd0, addr_hi_o}, {24'd0, addr[15:8]});
    chk_eq("R2", "strobes idle in first clock", {30'd0, rd_n_o, wr_n_o}, 3);
    chk_eq("R4", "status", {29'd0, status_o}, {29'd0, kind});
    @(negedge clk_i);
    ad_i = rdval;
    if (hold_mid) hold_i = 1'b1;
    chk_eq("R2", "ale low in data clock", {31'd0, ale_o}, 0);
    chk_eq("R3", "strobes second clock", {30'd0, rd_n_o, wr_n_o}, {30'd0, !is_rd, !is_wr});
    if (is_wr) chk_eq("R5", "write data driven", {23'd0, ad_oe_o, ad_o}, {23'd0, 1'b1, wdata});
    else       chk_eq("R5", "ad floated for non-write", {31'd0, ad_oe_o}, 0);
    for (int i = 0; i < waits; i++) begin
      @(negedge clk_i);
      chk_eq("R6", "wait keeps strobes", {30'd0, rd_n_o, wr_n_o}, {30'd0, !is_rd, !is_wr});
      chk_eq("R6", "wait keeps addr/status", {21'd0, addr_hi_o, status_o}, {21'd0, addr[15:8], kind});
      chk_eq("R6", "no done during wait", {31'd0, done_o}, 0);
      if (hold_mid) chk_eq("R8", "no ack mid cycle", {31'd0, hold_ack_o}, 0);
      if (i == waits - 1) ready_i = 1'b1;
    end
    @(negedge clk_i);
    chk_eq("R3", "strobes last clock", {30'd0, rd_n_o, wr_n_o}, {30'd0, !is_rd, !is_wr});
    chk_eq("R7", "done not early", {31'd0, done_o}, 0);
    if (hold_mid) chk_eq("R8", "no ack in last clock", {31'd0, hold_ack_o}, 0);
    @(negedge clk_i);
    chk_eq("R7", "done pulse", {31'd0, done_o}, 1);
    chk_eq("R3", "strobes released", {30'd0, rd_n_o, wr_n_o}, 3);
    chk_eq("R5", "ad floated after cycle", {31'd0, ad_oe_o}, 0);
    if (is_rd) chk_eq("R7", "read data", {24'd0, rdata_o}, {24'd0, rdval});
    if (hold_mid) chk_eq("R8", "no ack at boundary clock", {31'd0, hold_ack_o}, 0);
    ready_i = 1'b1;
  endtask

  task automatic t_reset();
    #(CLK_PERIOD * 2 + 2);
    chk_eq("R1", "enables in reset", {29'd0, ad_oe_o, addr_hi_oe_o, ctrl_oe_o}, 0);
    chk_eq("R1", "ack and strobes in reset", {29'd0, hold_ack_o, rd_n_o, wr_n_o}, 3);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_eq("R1", "enables after reset", {30'd0, addr_hi_oe_o, ctrl_oe_o}, 3);
  endtask

  task automatic t_reads_writes();
    do_cycle(3'b010, 16'h12A5, 8'h00, 0, 8'h3C, 0);   // memory read
    do_cycle(3'b101, 16'h0077, 8'hE1, 2, 8'h00, 0);   // I/O write, two waits
    do_cycle(3'b011, 16'hBEEF, 8'h00, 1, 8'h5A, 0);   // fetch, one wait
    do_cycle(3'b001, 16'h8001, 8'h96, 0, 8'h00, 0);   // memory write
    do_cycle(3'b110, 16'h0040, 8'h00, 3, 8'hC3, 0);   // I/O read
    do_cycle(3'b111, 16'hFFFF, 8'h00, 0, 8'h81, 0);   // interrupt ack
    do_cycle(3'b000, 16'h4321, 8'h00, 0, 8'h00, 0);   // halt: no strobe
    chk_eq("R7", "halt keeps last read byte", {24'd0, rdata_o}, 32'h81);
  endtask

  task automatic t_hold_idle();
    @(negedge clk_i);
    hold_i = 1'b1; req_valid_i = 1'b1; req_kind_i = 3'b010; req_addr_i = 16'h5511;
    @(negedge clk_i);
    chk_eq("R8", "hold beats pending request", {31'd0, ale_o}, 0);
    for (int i = 0; i < 3; i++) begin
      chk_eq("R9", "ack during hold", {31'd0, hold_ack_o}, 1);
      chk_eq("R9", "all floated", {28'd0, ad_oe_o, addr_hi_oe_o, ctrl_oe_o, req_ready_o}, 0);
      @(negedge clk_i);
    end
    hold_i = 1'b0;
    @(negedge clk_i);
    chk_eq("R10", "ack drops one clock after release", {31'd0, hold_ack_o}, 0);
    chk_eq("R10", "no start yet", {31'd0, ale_o}, 0);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk_eq("R10", "pending request starts", {31'd0, ale_o}, 1);
    chk_eq("R10", "pending addr", {24'd0, ad_o}, 32'h11);
    repeat (3) @(negedge clk_i);
    chk_eq("R7", "done after released request", {31'd0, done_o}, 1);
  endtask

  task automatic t_hold_mid();
    do_cycle(3'b010, 16'h2468, 8'h00, 2, 8'h7E, 1);
    @(negedge clk_i);
    chk_eq("R8", "ack after cycle ends", {31'd0, hold_ack_o}, 1);
    chk_eq("R9", "floated after ack", {29'd0, ad_oe_o, addr_hi_oe_o, ctrl_oe_o}, 0);
    hold_i = 1'b0;
    @(negedge clk_i);
    chk_eq("R10", "ack released", {31'd0, hold_ack_o}, 0);
  endtask

  initial begin
    t_reset();
    t_reads_writes();
    t_hold_idle();
    t_hold_mid();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule